// File: doc/BRIEF.md
# Asynchronous ROM Read Cycle Controller

This block lets synchronous logic read a parallel, asynchronous, mask-programmed ROM that offers both an 8-bit and a 16-bit organisation. The host presents a request together with a byte address and a width flag. The controller then drives the ROM address, chip enable and output enable. It waits until every access interval of the ROM has run out, counted in whole clock cycles, and captures the data bus. It returns the result with a one-cycle valid pulse and closes the bus again. A new cycle can only start after the bus has had time to float and the minimum read cycle time has passed.

Every analog timing figure is a parameter given in picoseconds, together with the clock period. The controller rounds each figure up to a whole number of cycles. Chip enable and the address go out together. Output enable follows one cycle later. The capture edge is the latest of the three intervals, each measured from the point where its own signal was asserted. In 8-bit mode the lowest address bit leaves the block on a pin that the ROM shares with data bit 15. In 16-bit mode the controller releases that pin and reads it as data bit 15.

Top module: `rom_read_ctrl`

## Requirements
- R1: After reset, `busy_o`, `rvalid_o` and `rom_lsb_oe_o` are 0, `rom_ce_no` and `rom_oe_no` are 1, and `rdata_o` is 0.
- R2: A request is taken only when the controller is idle. `busy_o` is 1 from the edge that takes it until the edge where the controller returns to idle. A request raised while busy has no effect.
- R3: At the edge that takes a request, `rom_addr_o` is loaded with `addr_i[ADDR_W-1:1]` and `rom_ce_no` goes low. `rom_oe_no` goes low one edge later. Address, enables and width stay unchanged until capture.
- R4: The bus is sampled at edge K after the request edge, where K = max(ceil(T_AA/CLK), ceil(T_ACE/CLK), 1+ceil(T_OE/CLK), 2). At that same edge `rvalid_o` rises for exactly one cycle and both enables return high.
- R5: In 8-bit mode (`byte_mode_i`=1), `rom_lsb_o` carries `addr_i[0]` and `rom_lsb_oe_o` is 1 while busy. `rdata_o[7:0]` is `rom_d_i[7:0]`, and `rdata_o[15:8]` is 0.
- R6: In 16-bit mode, `rom_lsb_oe_o` stays 0. `rdata_o` is all of `rom_d_i[15:0]`, with bit 15 read from the shared pin. `addr_i[0]` does not affect the ROM address.
- R7: The controller returns to idle at edge R = max(max(K+ceil(T_FLOAT/CLK), ceil(T_RC/CLK))-1, K+2). Between two cycles, the enables therefore stay high for at least the float time, and chip-enable falls are at least the read cycle time apart.
- R8: `rom_word_o` is 1 for a 16-bit access and 0 for an 8-bit access. It takes the new value at the edge that takes the request and holds it until the next request is taken (reset value 0).
- R9: `rdata_o` changes only at a capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request |
| addr_i | input | ADDR_W | Byte address |
| byte_mode_i | input | 1 | 1 = 8-bit access, 0 = 16-bit access |
| busy_o | output | 1 | A read cycle is in progress |
| rvalid_o | output | 1 | One-cycle pulse: `rdata_o` is new |
| rdata_o | output | DATA_W | Read result |
| rom_addr_o | output | ADDR_W-1 | ROM word address pins |
| rom_ce_no | output | 1 | ROM chip enable, active low |
| rom_oe_no | output | 1 | ROM output enable, active low |
| rom_word_o | output | 1 | ROM width select, 1 = 16-bit |
| rom_lsb_o | output | 1 | Value driven onto the shared LSB/D15 pin |
| rom_lsb_oe_o | output | 1 | Drive enable for the shared pin |
| rom_d_i | input | DATA_W | ROM data bus; bit 15 is the shared pin |

## Verification
The bench builds the controller with an 8-bit address, a 10 ns clock and these times: address access 30 ns, chip-enable access 25 ns, output-enable delay 45 ns, read cycle 100 ns and float 75 ns. With this set the output-enable path decides the capture edge (K=6), because its one-cycle offset makes it outlast the other two paths. The float time decides the return to idle (R=13). A model ROM in the bench returns junk until each of its own interval counters has run out, so a capture that comes too early shows up as wrong data. The small address space makes it cheap to hit both byte lanes, a bit 15 that is set, and the same address read twice in a row.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_CAPTURE,
    ST_RELEASE
  } rd_state_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rom_rd_timer.sv
module rom_rd_timer #(
  parameter int unsigned SAMPLE_AT = 10,
  parameter int unsigned IDLE_AT   = 13,
  parameter int unsigned CNT_W     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sample_o,
  output logic done_o
);

  logic [CNT_W-1:0] elapsed_q;

  // cycles since the edge that started the current access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     elapsed_q <= '0;
    else if (!run_i) elapsed_q <= '0;
    else             elapsed_q <= elapsed_q + 1'b1;
  end

  assign sample_o = (elapsed_q == CNT_W'(SAMPLE_AT - 1));
  assign done_o   = (elapsed_q == CNT_W'(IDLE_AT - 1));

  assert_elapsed_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elapsed_q <= CNT_W'(IDLE_AT));

  assert_idle_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> elapsed_q == '0);

endmodule

// File: rtl/rom_rd_fsm.sv
module rom_rd_fsm import rom_rd_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic sample_i,
  input  logic done_i,
  output logic accept_o,
  output logic capture_o,
  output logic busy_o,
  output logic rvalid_o,
  output logic ce_no,
  output logic oe_no
);

  rd_state_e state_q, state_d;
  logic      ce_n_q, oe_n_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i)    state_d = ST_SETUP;
      ST_SETUP:                 state_d = ST_WAIT;
      ST_WAIT:    if (sample_i) state_d = ST_CAPTURE;
      ST_CAPTURE:               state_d = ST_RELEASE;
      ST_RELEASE: if (done_i)   state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      // enables registered from the next state: no glitch on the pins
      ce_n_q  <= !(state_d == ST_SETUP || state_d == ST_WAIT);
      oe_n_q  <= !(state_d == ST_WAIT);
    end
  end

  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign capture_o = (state_q == ST_WAIT) && sample_i;
  assign busy_o    = (state_q != ST_IDLE);
  assign rvalid_o  = (state_q == ST_CAPTURE);
  assign ce_no     = ce_n_q;
  assign oe_no     = oe_n_q;

  assert_oe_inside_ce_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_q |-> !ce_n_q);

  assert_oe_follows_ce_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_n_q) |-> !$past(ce_n_q));

  assert_rvalid_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  assert_capture_closes_bus_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (ce_n_q && oe_n_q));

  assert_setup_from_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP) |-> ($past(state_q) == ST_IDLE));

endmodule

// File: rtl/rom_rd_datapath.sv
module rom_rd_datapath #(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic              active_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_mode_i,
  input  logic [DATA_W-1:0] rom_d_i,
  output logic [ADDR_W-2:0] rom_addr_o,
  output logic              rom_lsb_o,
  output logic              rom_lsb_oe_o,
  output logic              rom_word_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned LANE_W = DATA_W / 2;

  logic [ADDR_W-2:0] waddr_q;
  logic              lsb_q;
  logic              word_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] lane_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waddr_q <= '0;
      lsb_q   <= 1'b0;
      word_q  <= 1'b0;
    end else if (accept_i) begin
      waddr_q <= addr_i[ADDR_W-1:1];
      lsb_q   <= addr_i[0];
      word_q  <= !byte_mode_i;
    end
  end

  // byte access: ROM puts the chosen byte on the low lane
  assign lane_sel = word_q ? rom_d_i : {{LANE_W{1'b0}}, rom_d_i[LANE_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= lane_sel;
  end

  assign rom_addr_o   = waddr_q;
  assign rom_lsb_o    = lsb_q;
  assign rom_lsb_oe_o = active_i && !word_q;
  assign rom_word_o   = word_q;
  assign rdata_o      = rdata_q;

  assert_word_releases_pin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_word_o |-> !rom_lsb_oe_o);

  assert_byte_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(capture_i) && !word_q) |-> (rdata_q[DATA_W-1:LANE_W] == '0));

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(capture_i) |-> $stable(rdata_q));

  assert_addr_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(active_i) && active_i) |-> ($stable(rom_addr_o) && $stable(rom_word_o)));

endmodule

// File: rtl/rom_read_ctrl.sv
module rom_read_ctrl import rom_rd_pkg::*; #(
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CLK_PS     = 10000,
  parameter int unsigned T_RC_PS    = 100000,
  parameter int unsigned T_AA_PS    = 100000,
  parameter int unsigned T_ACE_PS   = 100000,
  parameter int unsigned T_OE_PS    = 50000,
  parameter int unsigned T_FLOAT_PS = 40000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_mode_i,
  output logic              busy_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-2:0] rom_addr_o,
  output logic              rom_ce_no,
  output logic              rom_oe_no,
  output logic              rom_word_o,
  output logic              rom_lsb_o,
  output logic              rom_lsb_oe_o,
  input  logic [DATA_W-1:0] rom_d_i
);

  localparam int unsigned AA_CYC    = ceil_div(T_AA_PS, CLK_PS);
  localparam int unsigned ACE_CYC   = ceil_div(T_ACE_PS, CLK_PS);
  localparam int unsigned OE_CYC    = ceil_div(T_OE_PS, CLK_PS);
  localparam int unsigned RC_CYC    = ceil_div(T_RC_PS, CLK_PS);
  localparam int unsigned FLOAT_CYC = ceil_div(T_FLOAT_PS, CLK_PS);
  // output enable starts one cycle after address and chip enable
  localparam int unsigned SAMPLE_AT = max2(max2(AA_CYC, ACE_CYC), max2(OE_CYC + 1, 2));
  localparam int unsigned IDLE_AT   = max2(max2(SAMPLE_AT + FLOAT_CYC, RC_CYC) - 1,
                                           SAMPLE_AT + 2);
  localparam int unsigned CNT_W     = $clog2(IDLE_AT + 1);

  logic accept, capture, sample, done;

  rom_rd_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .sample_i  (sample),
    .done_i    (done),
    .accept_o  (accept),
    .capture_o (capture),
    .busy_o    (busy_o),
    .rvalid_o  (rvalid_o),
    .ce_no     (rom_ce_no),
    .oe_no     (rom_oe_no)
  );

  rom_rd_timer #(
    .SAMPLE_AT (SAMPLE_AT),
    .IDLE_AT   (IDLE_AT),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy_o),
    .sample_o (sample),
    .done_o   (done)
  );

  rom_rd_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .capture_i    (capture),
    .active_i     (busy_o),
    .addr_i       (addr_i),
    .byte_mode_i  (byte_mode_i),
    .rom_d_i      (rom_d_i),
    .rom_addr_o   (rom_addr_o),
    .rom_lsb_o    (rom_lsb_o),
    .rom_lsb_oe_o (rom_lsb_oe_o),
    .rom_word_o   (rom_word_o),
    .rdata_o      (rdata_o)
  );

  assert_ce_only_when_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_ce_no |-> busy_o);

  assert_pulse_while_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> busy_o);

endmodule

// File: tb/rom_read_ctrl_bench.sv
module rom_read_ctrl_bench;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int CLK_PS = 10000;
  localparam int T_RC   = 100000;
  localparam int T_AA   = 30000;
  localparam int T_ACE  = 25000;
  localparam int T_OE   = 45000;
  localparam int T_FLT  = 75000;

  localparam int AA_C  = (T_AA + CLK_PS - 1) / CLK_PS;
  localparam int ACE_C = (T_ACE + CLK_PS - 1) / CLK_PS;
  localparam int OE_C  = (T_OE + CLK_PS - 1) / CLK_PS;
  localparam int RC_C  = (T_RC + CLK_PS - 1) / CLK_PS;
  localparam int FLT_C = (T_FLT + CLK_PS - 1) / CLK_PS;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int K_EDGE = imax(imax(AA_C, ACE_C), imax(OE_C + 1, 2));
  localparam int R_EDGE = imax(imax(K_EDGE + FLT_C, RC_C) - 1, K_EDGE + 2);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              byte_mode = 1'b0;
  logic              busy, rvalid, ce_n, oe_n, word_pin, lsb_pin, lsb_oe;
  logic [DATA_W-1:0] rdata;
  logic [ADDR_W-2:0] rom_addr;
  logic [DATA_W-1:0] rom_d = '0;

  always #5ns clk = ~clk;

  rom_read_ctrl #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CLK_PS (CLK_PS), .T_RC_PS (T_RC),
    .T_AA_PS (T_AA), .T_ACE_PS (T_ACE), .T_OE_PS (T_OE), .T_FLOAT_PS (T_FLT)
  ) u_rom_read_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .addr_i (addr),
    .byte_mode_i (byte_mode), .busy_o (busy), .rvalid_o (rvalid), .rdata_o (rdata),
    .rom_addr_o (rom_addr), .rom_ce_no (ce_n), .rom_oe_no (oe_n),
    .rom_word_o (word_pin), .rom_lsb_o (lsb_pin), .rom_lsb_oe_o (lsb_oe),
    .rom_d_i (rom_d)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic eq(input string tag, input string what,
                    input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, what, act, exp);
  endtask

  task automatic end_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [15:0] rom_word(input logic [ADDR_W-2:0] a);
    int v;
    v = int'(a);
    return 16'((v * 40503 + 4660) ^ (v << 9));
  endfunction

  // reference model, advanced on the rising edge
  int                t_ref = -1;
  logic [ADDR_W-1:0] m_addr = '0;
  logic              m_word = 1'b0;
  logic [15:0]       m_rdata = '0;
  int                n_rvalid = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_ref = -1; m_addr = '0; m_word = 1'b0; m_rdata = '0;
    end else if (t_ref < 0) begin
      if (req) begin
        t_ref = 0; m_addr = addr; m_word = !byte_mode;
      end
    end else begin
      t_ref++;
      if (t_ref == K_EDGE) begin
        if (m_word) m_rdata = rom_word(m_addr[ADDR_W-1:1]);
        else m_rdata = {8'h00, m_addr[0] ? rom_word(m_addr[ADDR_W-1:1])[15:8]
                                         : rom_word(m_addr[ADDR_W-1:1])[7:0]};
        n_rvalid++;
      end
      if (t_ref == R_EDGE) t_ref = -1;
    end
  end

  // ROM model state and per-cycle comparison, away from the rising edge
  int a_age = 1000, ce_age = 0, oe_age = 0, off_cnt = 1000, since_fall = 1000;
  bit prev_ce_n = 1'b1, seen_fall = 1'b0;
  logic [ADDR_W-1:0] prev_pins = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit   act;
      logic [15:0] w;
      act = (t_ref >= 0);
      eq("R2", "busy", busy, act);
      eq("R3", "ce_n", ce_n, !(act && t_ref < K_EDGE));
      eq("R3", "oe_n", oe_n, !(act && t_ref >= 1 && t_ref < K_EDGE));
      eq("R4", "rvalid", rvalid, (t_ref == K_EDGE));
      eq("R3", "rom_addr", rom_addr, m_addr[ADDR_W-1:1]);
      eq("R8", "word_pin", word_pin, m_word);
      if (m_word) eq("R6", "lsb_oe", lsb_oe, 1'b0);
      else begin
        eq("R5", "lsb_oe", lsb_oe, act);
        eq("R5", "lsb_pin", lsb_pin, m_addr[0]);
      end
      if (t_ref == K_EDGE) eq(m_word ? "R6" : "R5", "rdata", rdata, m_rdata);
      else eq("R9", "rdata_hold", rdata, m_rdata);

      since_fall++;
      if (prev_ce_n && !ce_n) begin
        if (seen_fall) begin
          chk(off_cnt >= FLT_C, "R7", "float_gap", off_cnt, FLT_C);
          chk(since_fall >= RC_C, "R7", "cycle_gap", since_fall, RC_C);
        end
        seen_fall = 1'b1;
        since_fall = 0;
      end

      if (ce_n) off_cnt++; else off_cnt = 0;
      if ({rom_addr, lsb_pin} != prev_pins) a_age = 1; else a_age++;
      if (!ce_n) ce_age++; else ce_age = 0;
      if (!oe_n) oe_age++; else oe_age = 0;
      prev_pins = {rom_addr, lsb_pin};
      prev_ce_n = ce_n;

      w = rom_word(rom_addr);
      if (!ce_n && !oe_n && a_age >= AA_C && ce_age >= ACE_C && oe_age >= OE_C)
        rom_d <= word_pin ? w : {8'hC3, lsb_pin ? w[15:8] : w[7:0]};
      else
        rom_d <= 16'hBAD5;
    end
  end

  task automatic do_read(input logic [ADDR_W-1:0] a, input bit bmode);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; addr = a; byte_mode = bmode;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      checks++; errors++;
      $display("FAIL R2 watchdog act=%0d exp=done", wd);
      end_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    eq("R1", "busy", busy, 1'b0);
    eq("R1", "rvalid", rvalid, 1'b0);
    eq("R1", "ce_n", ce_n, 1'b1);
    eq("R1", "oe_n", oe_n, 1'b1);
    eq("R1", "lsb_oe", lsb_oe, 1'b0);
    eq("R1", "rdata", rdata, 16'h0);

    do_read(8'h24, 1'b1);          // R5 low byte
    do_read(8'h25, 1'b1);          // R5 high byte, same word
    do_read(8'h3B, 1'b0);          // R6 odd address in word mode
    do_read(8'hFE, 1'b0);          // R6 top word
    do_read(8'hFE, 1'b0);          // R3 same address again
    do_read(8'h81, 1'b1);          // R8 switch back to byte
    // R2 requests raised while busy have no effect
    @(negedge clk);
    while (!busy) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      req = 1'b1; addr = 8'h10 + 8'(i); byte_mode = 1'b0;
      @(negedge clk);
      req = 1'b0;
      @(negedge clk);
    end
    wait_idle();
    // R7 request held high: back-to-back accesses at the minimum spacing
    begin
      int start_n;
      start_n = n_rvalid;
      req = 1'b1; addr = 8'h5A; byte_mode = 1'b0;
      while (n_rvalid < start_n + 3) @(negedge clk);
      req = 1'b0;
      eq("R7", "back_to_back_count", n_rvalid - start_n, 3);
    end
    wait_idle();
    do_read(8'h7F, 1'b1);
    wait_idle();
    repeat (5) @(negedge clk);
    eq("R9", "final_rdata_held", rdata, m_rdata);
    end_run();
  end

endmodule